// File: doc/BRIEF.md
# Pipelined ADC-to-Memory Transfer Sequencer

This block fills a region of word-addressed memory with converter results without processor help. Software gives it a start address and a word count and pulses `start`. From then on the sequencer runs a series of transfer steps. One step lasts as long as one conversion and is clocked from the converter's clock. Each step overlaps three jobs. It converts the channel whose code was fetched in the step before. It stores the result of the step before's conversion, tagged with that conversion's channel. It fetches the channel code for the next step from memory.

The channel list sits in the same memory region that receives the results. Each result overwrites the code that selected it. When all requested words are stored, or when a fetched code equals the stop marker, the sequencer drains whatever is still in flight. It then raises a sticky interrupt and goes idle.

While a transfer into the external region runs, processor requests to the external port are swallowed. The processor still sees its access complete. A transfer whose whole region lies in internal memory leaves the external port to the processor.

Top module: `adc_dma_seq`

## Requirements
- R1: After reset the sequencer is idle, with `irq`, `mem_en`, `adc_start` and `ext_block` all low. While idle it makes no memory access and starts no conversion.
- R2: `adc_start` is a one-cycle pulse, issued once per step. The channels are converted in the order their codes appear in the list. Each is converted in the step after the step that fetched its code.
- R3: The result of conversion k is written to address `start_addr + k`. The written word carries the channel in bits 15:12 and the 12-bit result in bits 11:0. Writes come in conversion order, and the stop marker never appears as a stored channel.
- R4: The code for conversion k is read from address `start_addr + k`, in ascending order. Only bits 3:0 of the read word are used. At most `xfer_len` reads happen per transfer.
- R5: The first result is written in the third step. At the first write, exactly min(number of conversions, 2) conversion starts have been issued.
- R6: `irq` rises once the last result is stored. It stays high until `irq_clr` is pulsed, and the clear takes effect on the next clock.
- R7: A fetched code of 4'hF is not converted, and no further codes are read. Results already in flight are still written, and then `irq` is raised.
- R8: A `start` pulse that arrives while a transfer is active is ignored. It changes neither the addresses nor the channels of the running transfer.
- R9: While a transfer whose region reaches address `INT_WORDS` or beyond is active, `ext_block` is high and `ext_en` and `ext_we` stay low. `cpu_ack` still follows `cpu_req`.
- R10: When the region lies wholly below `INT_WORDS` (`start_addr + xfer_len <= INT_WORDS`), the external port follows the processor request throughout the transfer.
- R11: A transfer of length zero makes no access, starts no conversion and raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a transfer when idle |
| start_addr | input | 8 | First word of the region |
| xfer_len | input | 8 | Number of words in the region |
| irq_clr | input | 1 | Clears the completion flag |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 16 | Stored word: channel and result |
| mem_rdata | input | 16 | Read word, valid the cycle after a read |
| adc_start | output | 1 | Conversion start pulse |
| adc_chan | output | 4 | Channel to convert |
| adc_done | input | 1 | Conversion finished pulse |
| adc_data | input | 12 | Conversion result, valid with `adc_done` |
| cpu_req | input | 1 | Processor external-port request |
| cpu_we | input | 1 | Processor write flag |
| cpu_addr | input | 8 | Processor address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_ack | output | 1 | Access completion seen by the processor |
| ext_en | output | 1 | External-port strobe after the gate |
| ext_we | output | 1 | External-port write after the gate |
| ext_addr | output | 8 | External-port address |
| ext_wdata | output | 16 | External-port write data |
| ext_block | output | 1 | High while processor accesses are suppressed |
| irq | output | 1 | Sticky completion interrupt |

## Verification
A step lasts five clocks when the conversion is short, and longer when the converter is slow. So no result has a fixed cycle number. The gate is the exception: it goes up on the clock after `start` is taken and comes down on the same edge that raises `irq`.

The first code read is issued on the third clock after the start is accepted. The first result write is due in the third step. The bench therefore counts conversion starts up to that write instead of counting clocks. Each read, conversion start and write is compared, at the falling edge where it is visible, against the next entry of a queue of expected events. The gate and port outputs are compared on every falling edge.

// File: rtl/adc_dma_pkg.sv
// Shared definitions for the converter-to-memory transfer sequencer.
// Assumes: one step walks the states in declaration order, LAUNCH to WAIT.
package adc_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WRITE,
        ST_READ,
        ST_CAPT,
        ST_WAIT
    } dma_state_e;
endpackage

// File: rtl/dma_addr_gen.sv
// Read and write address counters, and the remaining-read count.
// At load it also records whether the region lies wholly in internal memory.
// Assumes: load happens only while the sequencer is idle.
module dma_addr_gen #(
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 8,
    parameter int INT_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              rd_step,
    input  logic              wr_step,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              reads_done,
    output logic              region_int
);
    localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

    logic [LEN_W-1:0] reads_left;
    logic [SUM_W-1:0] region_end;

    // Purpose: one past the last word of the requested region.
    always_comb region_end = SUM_W'(start_addr) + SUM_W'(xfer_len);

    assign reads_done = (reads_left == '0);

    // Purpose: load the counters at start, then step them per access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr    <= '0;
            wr_addr    <= '0;
            reads_left <= '0;
            region_int <= 1'b0;
        end else if (load) begin
            rd_addr    <= start_addr;
            wr_addr    <= start_addr;
            reads_left <= xfer_len;
            region_int <= (region_end <= SUM_W'(INT_WORDS));
        end else begin
            if (rd_step) begin
                rd_addr    <= rd_addr + 1'b1;
                reads_left <= reads_left - 1'b1;
            end
            if (wr_step) begin
                wr_addr <= wr_addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ext_port_gate.sv
// Passes processor requests to the external port unless a transfer owns it.
// Assumes: the processor treats cpu_ack as completion and never waits on the port.
module ext_port_gate #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              active,
    input  logic              region_int,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic              ext_en,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [WORD_W-1:0] ext_wdata,
    output logic              ext_block
);
    // Purpose: suppress strobes during an external-region transfer.
    always_comb begin
        ext_block = active && !region_int;
        ext_en    = cpu_req && !ext_block;
        ext_we    = cpu_we && cpu_req && !ext_block;
        ext_addr  = cpu_addr;
        ext_wdata = cpu_wdata;
        cpu_ack   = cpu_req;
    end
endmodule

// File: rtl/dma_cycle_ctrl.sv
// Step sequencer. Each step launches the pending conversion, writes the
// previous result, reads the next code, and then waits for the converter.
// A three-deep pipeline of valid flags decides when the transfer has drained.
// Assumes: memory read data arrives one clock after the read, and adc_done
// comes at least one clock after adc_start.
module dma_cycle_ctrl
    import adc_dma_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int RES_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  irq_clr,
    input  logic                  reads_done,
    input  logic [CH_W-1:0]       mem_code,
    input  logic                  adc_done,
    input  logic [RES_W-1:0]      adc_data,
    output logic                  active,
    output logic                  load,
    output logic                  rd_step,
    output logic                  wr_step,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [CH_W+RES_W-1:0] mem_wdata,
    output logic                  adc_start,
    output logic [CH_W-1:0]       adc_chan,
    output logic                  irq
);
    dma_state_e       state;
    logic             conv_v, inflight, res_got, wr_v, fetch_v, rd_pend, stop_seen;
    logic [CH_W-1:0]  conv_id, wr_id, fetch_id;
    logic [RES_W-1:0] res_val, wr_res, res_now;
    logic             do_rd, do_wr, got, cycle_end, drained;

    // Purpose: per-state strobes and the end-of-step decision.
    always_comb begin
        active    = (state != ST_IDLE);
        load      = (state == ST_IDLE) && start;
        adc_start = (state == ST_LAUNCH) && conv_v;
        adc_chan  = conv_id;
        do_wr     = (state == ST_WRITE) && wr_v;
        do_rd     = (state == ST_READ) && !reads_done && !stop_seen;
        mem_en    = do_wr || do_rd;
        mem_we    = do_wr;
        mem_wdata = {wr_id, wr_res};
        rd_step   = do_rd;
        wr_step   = do_wr;
        got       = res_got || adc_done;
        res_now   = res_got ? res_val : adc_data;
        cycle_end = (state == ST_WAIT) && (!inflight || got);
        drained   = !inflight && !fetch_v && (reads_done || stop_seen);
    end

    // Purpose: walk the step states and advance the three-stage pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            conv_v    <= 1'b0;
            conv_id   <= '0;
            inflight  <= 1'b0;
            res_got   <= 1'b0;
            res_val   <= '0;
            wr_v      <= 1'b0;
            wr_id     <= '0;
            wr_res    <= '0;
            fetch_v   <= 1'b0;
            fetch_id  <= '0;
            rd_pend   <= 1'b0;
            stop_seen <= 1'b0;
        end else begin
            if (inflight && adc_done && !res_got) begin
                res_got <= 1'b1;
                res_val <= adc_data;
            end
            unique case (state)
                ST_IDLE: if (start) begin
                    conv_v    <= 1'b0;
                    wr_v      <= 1'b0;
                    fetch_v   <= 1'b0;
                    stop_seen <= 1'b0;
                    inflight  <= 1'b0;
                    state     <= ST_LAUNCH;
                end
                ST_LAUNCH: begin
                    inflight <= conv_v;
                    res_got  <= 1'b0;
                    state    <= ST_WRITE;
                end
                ST_WRITE: state <= ST_READ;
                ST_READ: begin
                    rd_pend <= do_rd;
                    state   <= ST_CAPT;
                end
                ST_CAPT: begin
                    if (rd_pend) begin
                        if (&mem_code) begin
                            stop_seen <= 1'b1;
                        end else begin
                            fetch_v  <= 1'b1;
                            fetch_id <= mem_code;
                        end
                    end
                    rd_pend <= 1'b0;
                    state   <= ST_WAIT;
                end
                ST_WAIT: if (cycle_end) begin
                    wr_v     <= inflight;
                    wr_id    <= conv_id;
                    wr_res   <= res_now;
                    conv_v   <= fetch_v;
                    conv_id  <= fetch_id;
                    fetch_v  <= 1'b0;
                    inflight <= 1'b0;
                    res_got  <= 1'b0;
                    state    <= drained ? ST_IDLE : ST_LAUNCH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: sticky completion flag; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (cycle_end && drained) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_dma_seq.sv
// Top of the converter-to-memory transfer sequencer. It joins the step
// controller, the address counters and the external-port gate.
// Assumes: the whole block is clocked from the converter clock domain.
module adc_dma_seq #(
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 8,
    parameter int CH_W      = 4,
    parameter int RES_W     = 12,
    parameter int INT_WORDS = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic [LEN_W-1:0]      xfer_len,
    input  logic                  irq_clr,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [CH_W+RES_W-1:0] mem_wdata,
    input  logic [CH_W+RES_W-1:0] mem_rdata,
    output logic                  adc_start,
    output logic [CH_W-1:0]       adc_chan,
    input  logic                  adc_done,
    input  logic [RES_W-1:0]      adc_data,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [CH_W+RES_W-1:0] cpu_wdata,
    output logic                  cpu_ack,
    output logic                  ext_en,
    output logic                  ext_we,
    output logic [ADDR_W-1:0]     ext_addr,
    output logic [CH_W+RES_W-1:0] ext_wdata,
    output logic                  ext_block,
    output logic                  irq
);
    localparam int WORD_W = CH_W + RES_W;

    logic              dma_active, load, rd_step, wr_step, reads_done, region_int;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              rdata_unused;

    assign rdata_unused = ^mem_rdata[WORD_W-1:CH_W];

    // Purpose: writes use the write counter, reads use the read counter.
    always_comb mem_addr = mem_we ? wr_addr : rd_addr;

    dma_cycle_ctrl #(.CH_W(CH_W), .RES_W(RES_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .irq_clr    (irq_clr),
        .reads_done (reads_done),
        .mem_code   (mem_rdata[CH_W-1:0]),
        .adc_done   (adc_done),
        .adc_data   (adc_data),
        .active     (dma_active),
        .load       (load),
        .rd_step    (rd_step),
        .wr_step    (wr_step),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .adc_start  (adc_start),
        .adc_chan   (adc_chan),
        .irq        (irq)
    );

    dma_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .INT_WORDS(INT_WORDS)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .start_addr (start_addr),
        .xfer_len   (xfer_len),
        .rd_step    (rd_step),
        .wr_step    (wr_step),
        .rd_addr    (rd_addr),
        .wr_addr    (wr_addr),
        .reads_done (reads_done),
        .region_int (region_int)
    );

    ext_port_gate #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_gate (
        .active     (dma_active),
        .region_int (region_int),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ack    (cpu_ack),
        .ext_en     (ext_en),
        .ext_we     (ext_we),
        .ext_addr   (ext_addr),
        .ext_wdata  (ext_wdata),
        .ext_block  (ext_block)
    );
endmodule

// File: rtl/adc_dma_seq_chk.sv
// Property checker for the transfer sequencer, bound to every instance of the top.
// Assumes: synchronous active-low reset on clk.
module adc_dma_seq_chk #(
    parameter int CH_W   = 4,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_active,
    input logic              mem_en,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              adc_start,
    input logic [CH_W-1:0]   adc_chan,
    input logic              irq,
    input logic              irq_clr,
    input logic              cpu_req,
    input logic              ext_en,
    input logic              ext_we,
    input logic              ext_block
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_active |-> (!mem_en && !adc_start));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    a_r7_marker_not_converted: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (adc_chan != {CH_W{1'b1}}));

    a_r3_marker_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_wdata[WORD_W-1 -: CH_W] != {CH_W{1'b1}}));

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    a_r9_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ext_block |-> (!ext_en && !ext_we));

    a_r9_block_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        ext_block |-> dma_active);

    a_r10_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_block |-> (ext_en == cpu_req));
endmodule

bind adc_dma_seq adc_dma_seq_chk #(.CH_W(CH_W), .WORD_W(CH_W + RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_active (dma_active),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .adc_start  (adc_start),
    .adc_chan   (adc_chan),
    .irq        (irq),
    .irq_clr    (irq_clr),
    .cpu_req    (cpu_req),
    .ext_en     (ext_en),
    .ext_we     (ext_we),
    .ext_block  (ext_block)
);

// File: tb/tb_adc_dma_seq.sv
// Bench: behavioural memory and converter models plus event-queue reference checks.
module tb_adc_dma_seq;
    localparam int ADDR_W = 8, LEN_W = 8, CH_W = 4, RES_W = 12, INT_WORDS = 64;
    localparam int WORD_W = CH_W + RES_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0, irq_clr = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic adc_start;
    logic [CH_W-1:0] adc_chan;
    logic adc_done = 1'b0;
    logic [RES_W-1:0] adc_data = '0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = 8'h33;
    logic [WORD_W-1:0] cpu_wdata = 16'h1234;
    logic cpu_ack, ext_en, ext_we, ext_block, irq;
    logic [ADDR_W-1:0] ext_addr;
    logic [WORD_W-1:0] ext_wdata;

    adc_dma_seq dut (.*);

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model: one-clock read latency plus a bench load port.
    logic [WORD_W-1:0] mem [256];
    logic ld_en = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [WORD_W-1:0] ld_data = '0;
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else mem_rdata <= mem[mem_addr];
        end
    end

    // Converter model: done arrives adc_lat clocks after start; expected words are logged.
    int adc_lat = 1, adc_cnt = 0, adc_seq = 0;
    int lat_chan = 0;
    int wd_q[$];
    always @(posedge clk) begin
        adc_done <= 1'b0;
        if (!rst_n) adc_cnt = 0;
        else if (adc_start) begin
            adc_cnt  = adc_lat;
            lat_chan = int'(adc_chan);
        end else if (adc_cnt > 0) begin
            adc_cnt--;
            if (adc_cnt == 0) begin
                int d;
                d = (lat_chan * 300 + adc_seq * 13) & 'hFFF;
                adc_done <= 1'b1;
                adc_data <= RES_W'(d);
                wd_q.push_back((lat_chan << 12) | d);
                adc_seq++;
            end
        end
    end

    // Reference model state.
    int rd_q[$], ch_q[$];
    bit exp_active = 0, exp_int = 0, irq_q = 0, first_wr = 0;
    int cur_addr = 0, wr_addr = 0, starts_seen = 0, exp_first = 0, wr_cnt = 0, rd_cnt = 0;

    // Per-clock comparison at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            exp_active = 0;
            irq_q = 0;
        end else begin
            bit blk;
            if (irq && !irq_q) exp_active = 0;
            irq_q = irq;
            blk = exp_active && !exp_int;
            chk(ext_block == blk, exp_int ? "R10" : "R9", "ext_block", ext_block, blk);
            chk(ext_en == (cpu_req && !blk), exp_int ? "R10" : "R9", "ext_en", ext_en, cpu_req && !blk);
            chk(cpu_ack == cpu_req, "R9", "cpu_ack", cpu_ack, cpu_req);
            if (adc_start) begin
                if (ch_q.size() == 0) chk(0, "R2", "unexpected conversion start", adc_chan, 0);
                else begin
                    int e;
                    e = ch_q.pop_front();
                    chk(int'(adc_chan) == e, "R2", "converted channel", adc_chan, e);
                end
                starts_seen++;
            end
            if (mem_en && !mem_we) begin
                rd_cnt++;
                if (rd_q.size() == 0) chk(0, "R4", "unexpected read", mem_addr, 0);
                else begin
                    int e;
                    e = rd_q.pop_front();
                    chk(int'(mem_addr) == e, "R4", "read address", mem_addr, e);
                end
            end
            if (mem_en && mem_we) begin
                if (first_wr) chk(starts_seen == exp_first, "R5", "starts before first write", starts_seen, exp_first);
                first_wr = 0;
                chk(int'(mem_addr) == (wr_addr & 'hFF), "R3", "write address", mem_addr, wr_addr & 'hFF);
                if (wd_q.size() == 0) chk(0, "R3", "unexpected write", mem_wdata, 0);
                else begin
                    int e;
                    e = wd_q.pop_front();
                    chk(int'(mem_wdata) == e, "R3", "written word", mem_wdata, e);
                end
                wr_addr++;
                wr_cnt++;
            end
            if (start && !exp_active) begin
                exp_active = 1;
                starts_seen = 0;
                first_wr = 1;
                wr_addr = cur_addr;
                wr_cnt = 0;
                rd_cnt = 0;
            end
        end
    end

    task automatic run_xfer(input int addr, input int len, input int ids[8], input int lat,
                            input bit poke, input string req);
        int nconv, nrd, wait_n;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            ld_en = 1'b1; ld_addr = ADDR_W'(addr + i); ld_data = 16'hBEE0 | WORD_W'(ids[i]);
        end
        @(posedge clk); #1; ld_en = 1'b0;
        nconv = 0; nrd = 0;
        for (int i = 0; i < len; i++) begin
            rd_q.push_back(addr + i);
            nrd++;
            if (ids[i] == 15) break;
            ch_q.push_back(ids[i]);
            nconv++;
        end
        exp_first = (nconv < 2) ? nconv : 2;
        exp_int = ((addr + len) <= INT_WORDS);
        cur_addr = addr;
        adc_lat = lat;
        start = 1'b1; start_addr = ADDR_W'(addr); xfer_len = LEN_W'(len);
        @(posedge clk); #1; start = 1'b0;
        wait_n = 0;
        while (!irq && wait_n < 3000) begin
            @(posedge clk); #1;
            wait_n++;
            if (poke && wait_n == 7) begin
                start = 1'b1; start_addr = 8'd150; xfer_len = 8'd3;
            end else start = 1'b0;
        end
        start = 1'b0;
        chk(irq == 1'b1, req, "transfer completion", irq, 1);
        @(posedge clk); #1;
        chk(ch_q.size() == 0, "R2", "conversions left over", ch_q.size(), 0);
        chk(rd_q.size() == 0, "R4", "reads left over", rd_q.size(), 0);
        chk(rd_cnt == nrd, "R4", "read count", rd_cnt, nrd);
        chk(wr_cnt == nconv, req, "write count", wr_cnt, nconv);
        if (poke) chk(wr_cnt == nconv && ch_q.size() == 0, "R8", "run unchanged by late start", wr_cnt, nconv);
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R6", "irq held until cleared", irq, 1);
        @(posedge clk); #1; irq_clr = 1'b1;
        @(posedge clk); #1; irq_clr = 1'b0;
        @(negedge clk);
        chk(irq == 1'b0, "R6", "irq cleared", irq, 0);
    endtask

    initial begin
        int ids[8];
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!irq && !mem_en && !adc_start && !ext_block, "R1", "outputs during reset",
            {irq, mem_en, adc_start, ext_block}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!irq && !mem_en && !adc_start && !ext_block, "R1", "idle after reset",
            {irq, mem_en, adc_start, ext_block}, 0);
        cpu_req = 1'b1; cpu_we = 1'b1;
        ids = '{3, 7, 0, 12, 5, 0, 0, 0};
        run_xfer(100, 5, ids, 4, 1'b1, "R3");
        ids = '{1, 14, 6, 0, 0, 0, 0, 0};
        run_xfer(10, 3, ids, 1, 1'b0, "R10");
        cpu_we = 1'b0;
        ids = '{2, 9, 15, 4, 4, 4, 0, 0};
        run_xfer(120, 6, ids, 3, 1'b0, "R7");
        run_xfer(200, 0, ids, 2, 1'b0, "R11");
        ids = '{8, 8, 1, 13, 0, 0, 0, 0};
        run_xfer(60, 4, ids, 2, 1'b0, "R10");
        run_xfer(61, 4, ids, 6, 1'b0, "R9");
        ids = '{11, 0, 0, 0, 0, 0, 0, 0};
        run_xfer(30, 1, ids, 2, 1'b0, "R5");
        cpu_req = 1'b0;
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule